// File: doc/BRIEF.md
# System Tick Timer

A 24-bit down-counting periodic timer on a simple single-cycle register bus. Software loads a reload value and enables the timer. The counter then decrements on every core clock cycle, or on each pulse of a reference-tick enable. When it passes from one to zero it raises a sticky wrap flag and can pulse an interrupt line for one cycle. On the following tick it reloads. The design keeps the reference clock in the core clock domain: it arrives as a single-cycle qualifying pulse.

The bus has four 32-bit words: control/status, reload, current count and calibration. An access marked unprivileged receives an error response and has no effect on any state. A read of control returns the wrap flag and clears it. A write of any data to the current count zeroes the counter and clears the flag. A reload of zero halts the counter while the enable bit stays set.

The calibration word is computed from parameters. It either reports that no reference tick exists, or gives the count of reference ticks in 10 ms minus one, together with a skew flag.

Top module: `sys_tick_timer`

## Requirements
- R1: Word offsets are 0x0 control, 0x4 reload, 0x8 current count and 0xC calibration. A read of any other offset returns zero with no error, and a write to any other offset, or to calibration, changes nothing.
- R2: While `bus_user` is 1, an access drives `bus_err` to 1 and `bus_rdata` to zero, and changes no register.
- R3: Control reads as bit 0 enable, bit 1 interrupt enable, bit 2 clock source (1 = core clock, 0 = reference tick) and bit 16 wrap flag. All other bits are zero. A write updates only bits [2:0].
- R4: A control read returns the wrap flag as it stood before the access, then clears it.
- R5: Reload holds 24 bits. Written bits [31:24] are dropped and read back as zero.
- R6: While running, the counter steps once per core cycle when the clock source is 1, and only on cycles with `ref_tick` high when it is 0. From zero it loads the reload value; otherwise it decrements.
- R7: A step from one to zero sets the wrap flag. If interrupt enable is set, `tick_irq` is high for exactly the following cycle.
- R8: A write of any data to offset 0x8 sets the counter to zero and clears the wrap flag. The next tick loads the reload value.
- R9: A tick that loads or wraps while reload is zero stops the counter and leaves the enable bit at 1. The counter resumes only after enable is written 0 and then 1.
- R10: Without a reference tick (`HAS_REF`=0), the clock-source bit reads 1 at all times, including after reset, and calibration reads 0x8000_0000.
- R11: With a reference tick, calibration bits [23:0] hold `REF_HZ`/100 minus one and bit 30 is set when `REF_HZ` is not a multiple of 100. With the defaults this gives 0x4000_0146.
- R12: After reset, control, reload and counter read zero (apart from R10), the timer is stopped and `tick_irq` is low.
- R13: When a wrap and a control read fall in the same cycle, the flag ends set. When a wrap and a count write fall in the same cycle, the write wins: the counter is zero, the flag is clear and no interrupt pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | Access is unprivileged |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response, valid in the access cycle |
| ref_tick | input | 1 | Single-cycle reference tick enable |
| tick_irq | output | 1 | One-cycle interrupt pulse after a wrap |

## Verification
Two events can land on the same clock edge: a counter wrap, and a bus access that touches the wrap flag or the counter. The bench uses the reference-tick mode to bring the counter to one at a known cycle. It then issues a control read, or a count write, in the very cycle that `ref_tick` is high. For the read, it expects the returned flag to be clear and the next read to show it set, with the interrupt pulse seen. For the write, it expects a zero counter, a clear flag and no interrupt pulse.

// File: rtl/tick_timer_pkg.sv
// Package: tick_timer_pkg
// Shared offsets, bit positions and the decoded register selector for the
// system tick timer. Assumes byte offsets on a 32-bit word bus.
package tick_timer_pkg;

    localparam int unsigned WORD_W = 32;

    // Word offsets decoded by the bus front end
    localparam int unsigned OFF_CTRL   = 'h0;
    localparam int unsigned OFF_RELOAD = 'h4;
    localparam int unsigned OFF_COUNT  = 'h8;
    localparam int unsigned OFF_CALIB  = 'hC;

    // Control/status bit positions
    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_IE_BIT   = 1;
    localparam int unsigned CTL_SRC_BIT  = 2;
    localparam int unsigned CTL_FLAG_BIT = 16;

    // Calibration bit positions
    localparam int unsigned CAL_NOREF_BIT = 31;
    localparam int unsigned CAL_SKEW_BIT  = 30;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_RELOAD,
        RSEL_COUNT,
        RSEL_CALIB
    } reg_sel_e;

    typedef struct packed {
        logic rd_ctrl;
        logic wr_ctrl;
        logic wr_reload;
        logic wr_count;
    } bus_strobe_t;

endpackage

// File: rtl/tt_bus_decode.sv
// Module: tt_bus_decode
// Decodes one bus access into a read selector and write/read strobes.
// Unprivileged accesses get an error and raise no strobe. Assumes the
// access is complete in a single cycle and the response is combinational.
module tt_bus_decode
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_user,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          rsel,
    output bus_strobe_t       strobe,
    output logic              err
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFF_CALIB);

    logic granted;

    // Privileged, valid access
    assign granted = bus_sel & ~bus_user;
    assign err     = bus_sel & bus_user;

    // Map the offset onto a register selector
    always_comb begin
        rsel = RSEL_NONE;
        if (granted) begin
            case (bus_addr)
                A_CTRL:   rsel = RSEL_CTRL;
                A_RELOAD: rsel = RSEL_RELOAD;
                A_COUNT:  rsel = RSEL_COUNT;
                A_CALIB:  rsel = RSEL_CALIB;
                default:  rsel = RSEL_NONE;
            endcase
        end
    end

    // Turn the selector and direction into side-effect strobes
    always_comb begin
        strobe.rd_ctrl   = (rsel == RSEL_CTRL)   & ~bus_wr;
        strobe.wr_ctrl   = (rsel == RSEL_CTRL)   &  bus_wr;
        strobe.wr_reload = (rsel == RSEL_RELOAD) &  bus_wr;
        strobe.wr_count  = (rsel == RSEL_COUNT)  &  bus_wr;
    end

endmodule

// File: rtl/tt_ctrl_reg.sv
// Module: tt_ctrl_reg
// Holds enable, interrupt enable, clock source and the sticky wrap flag,
// and produces the one-cycle interrupt pulse. A wrap outranks any flag
// clear in the same cycle. Without a reference tick the source bit is
// tied to the core clock.
module tt_ctrl_reg #(
    parameter bit HAS_REF = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       rd_ctrl,
    input  logic       wr_count,
    input  logic [2:0] wr_bits,
    input  logic       wrap,
    output logic       en,
    output logic       ie,
    output logic       src,
    output logic       flag,
    output logic       irq,
    output logic       start,
    output logic       stop
);

    // Enable edges seen by the counter
    assign start = wr_ctrl &  wr_bits[0] & ~en;
    assign stop  = wr_ctrl & ~wr_bits[0] &  en;

    // Writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            ie  <= 1'b0;
            src <= ~HAS_REF;
        end else if (wr_ctrl) begin
            en  <= wr_bits[0];
            ie  <= wr_bits[1];
            src <= HAS_REF ? wr_bits[2] : 1'b1;
        end
    end

    // Sticky wrap flag: set wins over read or count-write clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (rd_ctrl || wr_count) begin
            flag <= 1'b0;
        end
    end

    // One-cycle interrupt pulse following a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap & ie;
        end
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !wrap) |=> !flag);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wrap));

endmodule

// File: rtl/tt_counter.sv
// Module: tt_counter
// Reload register, down counter and run state. A count write outranks a
// tick in the same cycle. A load or wrap with a zero reload stops the
// counter; only a fresh enable edge restarts it. Assumes tick is already
// qualified by the selected clock source.
module tt_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reload,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic advance;
    logic at_zero;
    logic at_one;
    logic reload_zero;

    // Step qualification and wrap detection
    assign at_zero     = (count == CNT_ZERO);
    assign at_one      = (count == CNT_ONE);
    assign reload_zero = (reload == CNT_ZERO);
    assign advance     = running & tick & ~wr_count;
    assign wrap        = advance & at_one;

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= CNT_ZERO;
        end else if (wr_reload) begin
            reload <= wr_val;
        end
    end

    // Run state: enable edges, then zero-reload halts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (wr_count && reload_zero) begin
            running <= 1'b0;
        end else if (advance && reload_zero && (at_zero || at_one)) begin
            running <= 1'b0;
        end
    end

    // Counter: clear on write, else load from zero or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_ZERO;
        end else if (wr_count) begin
            count <= CNT_ZERO;
        end else if (advance) begin
            count <= at_zero ? reload : count - CNT_ONE;
        end
    end

    p_count_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count == CNT_ZERO));

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_count) |=> $stable(count));

    p_reload_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload |=> $stable(reload));

endmodule

// File: rtl/tt_calib.sv
// Module: tt_calib
// Builds the constant calibration word from parameters: either the
// no-reference marker, or the tick count in 10 ms minus one plus a skew
// bit when the reference rate is not a whole multiple of 100 Hz.
module tt_calib
    import tick_timer_pkg::*;
#(
    parameter bit          HAS_REF = 1'b1,
    parameter int unsigned REF_HZ  = 32768,
    parameter int unsigned CNT_W   = 24
) (
    output logic [WORD_W-1:0] calib
);

    localparam int unsigned     TICKS_10MS = REF_HZ / 100;
    localparam logic [WORD_W-1:0] TENMS    = WORD_W'(TICKS_10MS) - WORD_W'(1);
    localparam bit              SKEW       = (REF_HZ % 100) != 0;

    generate
        if (HAS_REF) begin : g_ref
            // Count field and skew marker
            always_comb begin
                calib               = '0;
                calib[CNT_W-1:0]    = TENMS[CNT_W-1:0];
                calib[CAL_SKEW_BIT] = SKEW;
            end
        end else begin : g_noref
            // Only the no-reference marker
            always_comb begin
                calib                = '0;
                calib[CAL_NOREF_BIT] = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/sys_tick_timer.sv
// Module: sys_tick_timer
// Top of the system tick timer: bus decode, control register, counter and
// calibration word, plus the read-data mux. Responses are combinational
// in the access cycle; side effects land on the next clock edge.
module sys_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CNT_W   = 24,
    parameter bit          HAS_REF = 1'b1,
    parameter int unsigned REF_HZ  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_user,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              ref_tick,
    output logic              tick_irq
);

    reg_sel_e          rsel;
    bus_strobe_t       strobe;
    logic              en, ie, src, flag, start, stop;
    logic              tick, running, wrap;
    logic [CNT_W-1:0]  count, reload;
    logic [WORD_W-1:0] calib;
    logic [WORD_W-1:0] ctrl_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    tt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_user (bus_user),
        .bus_addr (bus_addr),
        .rsel     (rsel),
        .strobe   (strobe),
        .err      (bus_err)
    );

    tt_ctrl_reg #(.HAS_REF(HAS_REF)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (strobe.wr_ctrl),
        .rd_ctrl  (strobe.rd_ctrl),
        .wr_count (strobe.wr_count),
        .wr_bits  (bus_wdata[2:0]),
        .wrap     (wrap),
        .en       (en),
        .ie       (ie),
        .src      (src),
        .flag     (flag),
        .irq      (tick_irq),
        .start    (start),
        .stop     (stop)
    );

    // Tick qualifier: every core cycle, or reference pulses only
    assign tick = src | ref_tick;

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_reload (strobe.wr_reload),
        .wr_count  (strobe.wr_count),
        .wr_val    (bus_wdata[CNT_W-1:0]),
        .start     (start),
        .stop      (stop),
        .tick      (tick),
        .count     (count),
        .reload    (reload),
        .running   (running),
        .wrap      (wrap)
    );

    tt_calib #(.HAS_REF(HAS_REF), .REF_HZ(REF_HZ), .CNT_W(CNT_W)) u_cal (
        .calib (calib)
    );

    // Assemble the control/status word
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[CTL_EN_BIT]   = en;
        ctrl_word[CTL_IE_BIT]   = ie;
        ctrl_word[CTL_SRC_BIT]  = src;
        ctrl_word[CTL_FLAG_BIT] = flag;
    end

    // Read-data mux; writes and denied accesses return zero
    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (rsel)
                RSEL_CTRL:   bus_rdata = ctrl_word;
                RSEL_RELOAD: bus_rdata = WORD_W'(reload);
                RSEL_COUNT:  bus_rdata = WORD_W'(count);
                RSEL_CALIB:  bus_rdata = calib;
                default:     bus_rdata = '0;
            endcase
        end
    end

    p_user_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_user) |-> (bus_err && bus_rdata == '0));

    p_user_nostate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_user) |=> $stable({en, ie, src, reload, running}));

    p_run_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> en);

endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, user = 1'b0, ref_tick = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        err0, err1, irq0, irq1;

    logic [31:0] s_rd, s_rd1;
    logic        s_err, s_irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sys_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_user(user),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd0), .bus_err(err0),
        .ref_tick(ref_tick), .tick_irq(irq0)
    );

    sys_tick_timer #(.HAS_REF(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_user(user),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd1), .bus_err(err1),
        .ref_tick(ref_tick), .tick_irq(irq1)
    );

    typedef struct packed {
        logic        w;
        logic        u;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic        er;
        logic [3:0]  rq;
    } vec_t;

    // Register-level vectors, timer stopped, no reference ticks
    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 8'h04, 32'hFFAB_CDEF, 32'h0,         1'b0, 4'd5},  // R5
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h00AB_CDEF, 1'b0, 4'd5},  // R5
        '{1'b1, 1'b0, 8'h00, 32'hFFFF_FFFA, 32'h0,         1'b0, 4'd3},  // R3
        '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0000_0002, 1'b0, 4'd3},  // R3
        '{1'b1, 1'b1, 8'h04, 32'h0000_0123, 32'h0,         1'b1, 4'd2},  // R2
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h00AB_CDEF, 1'b0, 4'd2},  // R2
        '{1'b0, 1'b1, 8'h00, 32'h0,         32'h0,         1'b1, 4'd2},  // R2
        '{1'b0, 1'b0, 8'h10, 32'h0,         32'h0,         1'b0, 4'd1},  // R1
        '{1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd1},  // R1
        '{1'b0, 1'b0, 8'h02, 32'h0,         32'h0,         1'b0, 4'd1},  // R1
        '{1'b0, 1'b0, 8'h0C, 32'h0,         32'h4000_0146, 1'b0, 4'd11}, // R11
        '{1'b1, 1'b0, 8'h0C, 32'h0,         32'h0,         1'b0, 4'd1},  // R1
        '{1'b0, 1'b0, 8'h0C, 32'h0,         32'h4000_0146, 1'b0, 4'd1},  // R1
        '{1'b1, 1'b1, 8'h00, 32'h0000_0007, 32'h0,         1'b1, 4'd2},  // R2
        '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0000_0002, 1'b0, 4'd2},  // R2
        '{1'b1, 1'b0, 8'h00, 32'h0000_0004, 32'h0,         1'b0, 4'd3},  // R3
        '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0000_0004, 1'b0, 4'd3},  // R3
        '{1'b0, 1'b0, 8'h08, 32'h0,         32'h0,         1'b0, 4'd1}   // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; outputs sampled mid-cycle before the committing edge
    task automatic acc(input logic w, input logic u, input logic [7:0] a,
                       input logic [31:0] d, input logic tk);
        @(negedge clk);
        sel = 1'b1; wr = w; user = u; addr = a; wdata = d; ref_tick = tk;
        #2;
        s_rd = rd0; s_err = err0; s_irq = irq0; s_rd1 = rd1;
        @(posedge clk);
        #1;
        sel = 1'b0; wr = 1'b0; user = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        acc(1'b0, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic wrt(input logic [7:0] a, input logic [31:0] d);
        acc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic idle(input logic tk);
        @(negedge clk);
        ref_tick = tk;
        #2;
        s_irq = irq0;
        @(posedge clk);
        #1;
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 / R10 / R11: reset state
        rd(8'h00); chk("R12 ctrl", s_rd, 32'h0);
        chk("R10 src forced", s_rd1, 32'h4);
        chk("R12 irq", {31'b0, s_irq}, 32'h0);
        rd(8'h04); chk("R12 reload", s_rd, 32'h0);
        rd(8'h08); chk("R12 count", s_rd, 32'h0);
        rd(8'h0C); chk("R11 calib", s_rd, 32'h4000_0146);
        chk("R10 calib noref", s_rd1, 32'h8000_0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            acc(TBL[i].w, TBL[i].u, TBL[i].a, TBL[i].d, 1'b0);
            chk($sformatf("R%0d err vec%0d", TBL[i].rq, i), {31'b0, s_err}, {31'b0, TBL[i].er});
            if (!TBL[i].w)
                chk($sformatf("R%0d data vec%0d", TBL[i].rq, i), s_rd, TBL[i].e);
        end

        // R10: writing source 0 leaves it at 1 without a reference
        wrt(8'h00, 32'h0);
        rd(8'h00); chk("R10 ctrl u0", s_rd, 32'h0); chk("R10 ctrl u1", s_rd1, 32'h4);

        // R6 / R7: core clock mode, reload 3, period 4
        wrt(8'h04, 32'h3);
        wrt(8'h08, 32'h5A);
        wrt(8'h00, 32'h7);
        rd(8'h08); chk("R6 c0", s_rd, 32'd0); chk("R7 i0", {31'b0, s_irq}, 32'd0);
        rd(8'h08); chk("R6 c1", s_rd, 32'd3); chk("R7 i1", {31'b0, s_irq}, 32'd0);
        rd(8'h08); chk("R6 c2", s_rd, 32'd2);
        rd(8'h08); chk("R6 c3", s_rd, 32'd1); chk("R7 i3", {31'b0, s_irq}, 32'd0);
        rd(8'h08); chk("R6 c4", s_rd, 32'd0); chk("R7 irq pulse", {31'b0, s_irq}, 32'd1);
        rd(8'h08); chk("R6 c5", s_rd, 32'd3); chk("R7 irq one cycle", {31'b0, s_irq}, 32'd0);
        rd(8'h00); chk("R4 flag seen", s_rd, 32'h0001_0007);
        rd(8'h00); chk("R4 flag cleared", s_rd, 32'h0000_0007);
        wrt(8'h00, 32'h0);

        // R6 / R8: reference tick mode
        wrt(8'h04, 32'h2);
        wrt(8'h08, 32'h0);
        wrt(8'h00, 32'h3);
        idle(1'b0); idle(1'b0); idle(1'b0);
        rd(8'h08); chk("R6 no ref tick", s_rd, 32'd0);
        idle(1'b1); idle(1'b0); idle(1'b0);
        rd(8'h08); chk("R6 ref load", s_rd, 32'd2);
        idle(1'b1); idle(1'b1);
        rd(8'h08); chk("R6 ref wrap", s_rd, 32'd0); chk("R7 ref irq", {31'b0, s_irq}, 32'd1);
        wrt(8'h08, 32'hDEAD_BEEF);
        rd(8'h00); chk("R8 flag cleared", s_rd, 32'h3);
        rd(8'h08); chk("R8 count zero", s_rd, 32'd0);
        idle(1'b1);
        rd(8'h08); chk("R8 reload next tick", s_rd, 32'd2);

        // R13: wrap with a control read in the same cycle
        idle(1'b1);
        acc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1); chk("R13 read old flag", s_rd, 32'h3);
        rd(8'h00); chk("R13 flag kept", s_rd, 32'h0001_0003);
        chk("R13 irq after read wrap", {31'b0, s_irq}, 32'd1);
        rd(8'h00); chk("R13 flag then clear", s_rd, 32'h3);

        // R13: wrap with a count write in the same cycle
        idle(1'b1); idle(1'b1);
        acc(1'b1, 1'b0, 8'h08, 32'h1, 1'b1);
        rd(8'h00); chk("R13 write wins flag", s_rd, 32'h3);
        chk("R13 no irq", {31'b0, s_irq}, 32'd0);
        rd(8'h08); chk("R13 write wins count", s_rd, 32'd0);

        // R9: zero reload at load halts, enable stays
        wrt(8'h04, 32'h0);
        idle(1'b1);
        wrt(8'h04, 32'h5);
        idle(1'b1); idle(1'b1); idle(1'b1);
        rd(8'h08); chk("R9 halted", s_rd, 32'd0);
        rd(8'h00); chk("R9 enable kept", s_rd, 32'h3);
        wrt(8'h00, 32'h3);
        idle(1'b1);
        rd(8'h08); chk("R9 rewrite enable no restart", s_rd, 32'd0);
        wrt(8'h00, 32'h2);
        wrt(8'h00, 32'h3);
        idle(1'b1);
        rd(8'h08); chk("R9 restart", s_rd, 32'd5);

        // R9: wrap with zero reload halts
        wrt(8'h04, 32'h0);
        idle(1'b1); idle(1'b1); idle(1'b1); idle(1'b1);
        idle(1'b1); idle(1'b1);
        rd(8'h08); chk("R9 wrap halt count", s_rd, 32'd0);
        rd(8'h00); chk("R9 wrap halt ctrl", s_rd, 32'h0001_0003);
        wrt(8'h04, 32'h1);
        idle(1'b1); idle(1'b1);
        rd(8'h08); chk("R9 stays halted", s_rd, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule